// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit processor that spreads each instruction over several clock cycles. A single memory serves both instruction fetch and data access, and a single ALU does every arithmetic step: incrementing the PC, computing results, comparing for branches, and forming data and branch addresses. Values that one cycle produces for a later cycle of the same instruction are held in hidden staging registers: the instruction register, the memory data register, the two operand registers and the ALU result register.

The sequencing controller is not part of this block. Every multiplexer select and write enable is a primary input, and the controller reads back the opcode, the function field and the ALU zero flag. The included memory has a second word-wide port, driven only by test, that loads programs and reads back stored words. Its write takes effect at the clock edge and has priority over a datapath write to the same word. The PC is visible at the ports.

Top module: `mc_datapath`

## Requirements
- R1: Reset clears the PC, the instruction register and the other staging registers to zero.
- R2: When `ir_load` is high, the instruction register takes the memory read data at the clock edge. When it is low, the instruction register holds its value. Opcode and function field are bits 31:26 and 5:0 of the instruction register.
- R3: The memory word index is PC[7:2] when `addr_sel` is 0 and ALU-result-register[7:2] when it is 1. Read data is zero while `mem_rd` is low. `mem_wr` stores the operand-B register at the edge.
- R4: ALU input A is the PC when `srca_sel` is 0 and the A register when it is 1. ALU input B is selected by `srcb_sel`: 0 = B register, 1 = constant 4, 2 = sign-extended IR[15:0], 3 = that value shifted left by two.
- R5: With `alu_mode` = 2, the function field selects the ALU operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0).
- R6: With `alu_mode` = 0 the ALU adds, and with `alu_mode` = 1 it subtracts, whatever the function field holds.
- R7: The PC loads when `pc_ld` is high, or when `pc_ld_if_zero` is high and the ALU zero flag is high. Otherwise it holds. Its next value is selected by `pc_sel`: 0 = ALU output, 1 = ALU result register, 2 = {PC[31:28], IR[25:0], 2'b00}.
- R8: A register write goes to IR[20:16] when `dst_sel` is 0 and to IR[15:11] when it is 1. It carries the ALU result register when `wb_sel` is 0 and the memory data register when it is 1. Register 0 reads as zero and ignores writes.
- R9: The operand registers take the register file entries addressed by IR[25:21] and IR[20:16] at every edge. `alu_zero` is high exactly when the ALU output is zero.
- R10: The test port writes word `tst_addr` with `tst_wdata` at the edge when `tst_we` is high, and `tst_rdata` shows word `tst_addr` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_ld | input | 1 | Unconditional PC write |
| pc_ld_if_zero | input | 1 | PC write qualified by ALU zero |
| pc_sel | input | 2 | PC next-value select |
| alu_mode | input | 2 | 0 add, 1 subtract, 2 decode function field |
| srca_sel | input | 1 | ALU input A select |
| srcb_sel | input | 2 | ALU input B select |
| addr_sel | input | 1 | Memory address source: PC or ALU result register |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable |
| wb_sel | input | 1 | Register write data select |
| rf_we | input | 1 | Register file write enable |
| ir_load | input | 1 | Instruction register load |
| dst_sel | input | 1 | Register write address select |
| tst_we | input | 1 | Test port write enable |
| tst_addr | input | 6 | Test port word index |
| tst_wdata | input | 32 | Test port write data |
| tst_rdata | output | 32 | Test port read data |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| alu_zero | output | 1 | ALU output equals zero |
| pc | output | 32 | Program counter |

## Verification
The bench goes after the signed set-less-than in both operand orders, a negative immediate through the sign-extend path, and a subtract that produces a negative value. A design that compared without sign, or that extended with zeros, would return wrong words for these. A branch is run both taken and not taken, so a datapath that ignored the zero qualifier would either always jump or never jump. Writes aimed at register 0 are stored back to memory and must read as zero. A fetch with the read enable low must load zero into the instruction register. A cycle with the instruction register's load low must leave the opcode unchanged, which catches an instruction register that reloads every cycle like the other staging registers.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT} alu_fn_e;

  function automatic alu_fn_e alu_decode(input logic [1:0] mode, input logic [5:0] fld);
    if (mode == 2'd1) return FN_SUB;
    if (mode != 2'd2) return FN_ADD;
    case (fld)
      6'h22:   return FN_SUB;
      6'h24:   return FN_AND;
      6'h25:   return FN_OR;
      6'h2A:   return FN_SLT;
      default: return FN_ADD;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_fn_e fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (fn)
      FN_SUB:  return a - b;
      FN_AND:  return a & b;
      FN_OR:   return a | b;
      FN_SLT:  return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk)
    if (we && waddr != '0) regs[waddr] <= wdata;

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [1:0]   mode,
  input  logic [5:0]   fld,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  alu_fn_e fn;
  assign fn   = alu_decode(mode, fld);
  assign y    = alu_eval(fn, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int W  = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] idx,
  input  logic          rd,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          t_we,
  input  logic [AW-1:0] t_idx,
  input  logic [W-1:0]  t_wdata,
  output logic [W-1:0]  t_rdata
);
  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (t_we) arr[t_idx] <= t_wdata;
    if (wr && !(t_we && t_idx == idx)) arr[idx] <= wdata;
  end

  assign rdata   = rd ? arr[idx] : '0;
  assign t_rdata = arr[t_idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREGS  = 32,
  localparam int W     = XLEN,
  localparam int RAW   = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_ld,
  input  logic              pc_ld_if_zero,
  input  logic [1:0]        pc_sel,
  input  logic [1:0]        alu_mode,
  input  logic              srca_sel,
  input  logic [1:0]        srcb_sel,
  input  logic              addr_sel,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              wb_sel,
  input  logic              rf_we,
  input  logic              ir_load,
  input  logic              dst_sel,
  input  logic              tst_we,
  input  logic [MEM_AW-1:0] tst_addr,
  input  logic [W-1:0]      tst_wdata,
  output logic [W-1:0]      tst_rdata,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic              alu_zero,
  output logic [W-1:0]      pc
);
  logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [W-1:0] mem_rdata, rf_a, rf_b, op_a, op_b, alu_y, pc_next, imm_x;
  logic [MEM_AW-1:0] mem_idx;
  logic [RAW-1:0] wr_addr;
  logic pc_en;

  // memory address mux: fetch from PC, data from ALU result register
  assign mem_idx = addr_sel ? res_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

  mc_mem #(.W(W), .AW(MEM_AW)) u_mem (
    .clk(clk), .idx(mem_idx), .rd(mem_rd), .wr(mem_wr), .wdata(b_q),
    .rdata(mem_rdata), .t_we(tst_we), .t_idx(tst_addr),
    .t_wdata(tst_wdata), .t_rdata(tst_rdata));

  assign wr_addr = dst_sel ? ir_q[15:11] : ir_q[20:16];

  mc_regfile #(.W(W), .N(NREGS)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wr_addr),
    .wdata(wb_sel ? mdr_q : res_q),
    .raddr_a(ir_q[25:21]), .raddr_b(ir_q[20:16]),
    .rdata_a(rf_a), .rdata_b(rf_b));

  assign imm_x = sext16(ir_q[15:0]);
  assign op_a  = srca_sel ? a_q : pc_q;

  always_comb
    case (srcb_sel)
      2'd0:    op_b = b_q;
      2'd1:    op_b = W'(4);
      2'd2:    op_b = imm_x;
      default: op_b = imm_x << 2;
    endcase

  mc_alu #(.W(W)) u_alu (
    .mode(alu_mode), .fld(ir_q[5:0]), .a(op_a), .b(op_b),
    .y(alu_y), .zero(alu_zero));

  always_comb
    case (pc_sel)
      2'd1:    pc_next = res_q;
      2'd2:    pc_next = {pc_q[W-1:W-4], ir_q[25:0], 2'b00};
      default: pc_next = alu_y;
    endcase

  assign pc_en = pc_ld | (pc_ld_if_zero & alu_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; ir_q <= '0; mdr_q <= '0; a_q <= '0; b_q <= '0; res_q <= '0;
    end else begin
      if (pc_en)   pc_q <= pc_next;
      if (ir_load) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf_a;
      b_q   <= rf_b;
      res_q <= alu_y;
    end
  end

  assign opcode = ir_q[31:26];
  assign funct  = ir_q[5:0];
  assign pc     = pc_q;

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(opcode) && $stable(funct));
  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_ld && !pc_ld_if_zero) |=> $stable(pc));
  // R7
  cond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld_if_zero && !pc_ld && !alu_zero) |=> $stable(pc));
  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && pc_sel == 2'd0 && !srca_sel && srcb_sel == 2'd1 && alu_mode == 2'd0)
      |=> pc == $past(pc) + W'(4));
endmodule

// File: tb/test_mc_datapath.sv
`timescale 1ns/100ps
module test_mc_datapath;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, pc_ld, pc_ld_if_zero, srca_sel, addr_sel, mem_rd, mem_wr;
  logic wb_sel, rf_we, ir_load, dst_sel, tst_we, alu_zero;
  logic [1:0] pc_sel, alu_mode, srcb_sel;
  logic [5:0] tst_addr, opcode, funct;
  logic [31:0] tst_wdata, tst_rdata, pc;

  mc_datapath i_mc_datapath (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] exp_pc = 0;
  logic zero_seen;

  // {rs, rt, funct, expected}; r1 = 7, r2 = -3
  localparam logic [47:0] VEC [7] = '{
    {5'd1, 5'd2, 6'h20, 32'h0000_0004},
    {5'd1, 5'd2, 6'h22, 32'h0000_000A},
    {5'd1, 5'd2, 6'h24, 32'h0000_0005},
    {5'd1, 5'd2, 6'h25, 32'hFFFF_FFFF},
    {5'd1, 5'd2, 6'h2A, 32'h0000_0000},
    {5'd2, 5'd1, 6'h2A, 32'h0000_0001},
    {5'd2, 5'd1, 6'h22, 32'hFFFF_FFF6}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic pcw, pcc, input logic [1:0] psrc, aop,
                     input logic asa, input logic [1:0] asb,
                     input logic iod, mr, mw, m2r, rw, irw, rdst);
    pc_ld = pcw; pc_ld_if_zero = pcc; pc_sel = psrc; alu_mode = aop;
    srca_sel = asa; srcb_sel = asb; addr_sel = iod; mem_rd = mr; mem_wr = mw;
    wb_sel = m2r; rf_we = rw; ir_load = irw; dst_sel = rdst;
    #1 zero_seen = alu_zero;
    @(posedge clk); @(negedge clk);
    {pc_ld, pc_ld_if_zero, pc_sel, alu_mode, srca_sel, srcb_sel} = '0;
    {addr_sel, mem_rd, mem_wr, wb_sel, rf_we, ir_load, dst_sel} = '0;
  endtask

  task automatic tput(input logic [5:0] a, input logic [31:0] d);
    tst_we = 1; tst_addr = a; tst_wdata = d;
    @(posedge clk); @(negedge clk);
    tst_we = 0;
  endtask

  task automatic tget(input logic [5:0] a, output logic [31:0] d);
    tst_addr = a; #1 d = tst_rdata;
  endtask

  task automatic place(input logic [31:0] ins); tput(exp_pc[7:2], ins); endtask
  task automatic fetch(); run(1,0,2'd0,2'd0,0,2'd1,0,1,0,0,0,1,0); exp_pc += 4; endtask
  task automatic decode(); run(0,0,2'd0,2'd0,0,2'd3,0,0,0,0,0,0,0); endtask
  task automatic do_r(); run(0,0,2'd0,2'd2,1,2'd0,0,0,0,0,0,0,0); run(0,0,2'd0,2'd0,0,2'd0,0,0,0,0,1,0,1); endtask
  task automatic do_lw();
    run(0,0,2'd0,2'd0,1,2'd2,0,0,0,0,0,0,0);
    run(0,0,2'd0,2'd0,0,2'd0,1,1,0,0,0,0,0);
    run(0,0,2'd0,2'd0,0,2'd0,0,0,0,1,1,0,0);
  endtask
  task automatic do_sw();
    run(0,0,2'd0,2'd0,1,2'd2,0,0,0,0,0,0,0);
    run(0,0,2'd0,2'd0,0,2'd0,1,0,1,0,0,0,0);
  endtask

  function automatic logic [31:0] rins(input logic [4:0] rs, rt, rd, input logic [5:0] f);
    return {6'h00, rs, rt, rd, 5'd0, f};
  endfunction
  function automatic logic [31:0] iins(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 0; tst_we = 0; tst_addr = 0; tst_wdata = 0;
    {pc_ld, pc_ld_if_zero, pc_sel, alu_mode, srca_sel, srcb_sel} = '0;
    {addr_sel, mem_rd, mem_wr, wb_sel, rf_we, ir_load, dst_sel} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 pc after reset", pc, 32'h0);
    check("R1 opcode after reset", {26'd0, opcode}, 32'h0);

    for (int i = 0; i < 64; i++) tput(6'(i), 32'h0);
    tput(6'd32, 32'h0000_0007);
    tput(6'd33, 32'hFFFF_FFFD);
    tget(6'd33, rd);
    check("R10 test port readback", rd, 32'hFFFF_FFFD);

    place(iins(6'h23, 5'd0, 5'd1, 16'd128));
    fetch();
    check("R2 opcode after fetch", {26'd0, opcode}, 32'h23);
    check("R2 pc step by four", pc, exp_pc);
    decode(); do_lw();
    place(iins(6'h23, 5'd0, 5'd2, 16'd132));
    fetch(); decode(); do_lw();

    // R5 R6 R8 R9: vector table of register-register operations
    for (int v = 0; v < 7; v++) begin
      place(rins(VEC[v][47:43], VEC[v][42:38], 5'd3, VEC[v][37:32]));
      fetch();
      check("R9 funct field", {26'd0, funct}, {26'd0, VEC[v][37:32]});
      decode(); do_r();
      place(iins(6'h2B, 5'd0, 5'd3, 16'd248));
      fetch(); decode(); do_sw();
      tget(6'd62, rd);
      check("R5 alu result stored via R3 path", rd, VEC[v][31:0]);
    end

    // R8: register 0 ignores writes
    place(rins(5'd1, 5'd1, 5'd0, 6'h20));
    fetch(); decode(); do_r();
    place(iins(6'h2B, 5'd0, 5'd0, 16'd248));
    fetch(); decode(); do_sw();
    tget(6'd62, rd);
    check("R8 register 0 stays zero", rd, 32'h0);

    // R7: branch taken, subtract via alu_mode 1 (R6), target uses shifted imm (R4)
    place(iins(6'h04, 5'd1, 5'd1, 16'd3));
    fetch(); decode();
    run(0,1,2'd1,2'd1,1,2'd0,0,0,0,0,0,0,0);
    check("R9 zero on equal operands", {31'd0, zero_seen}, 32'd1);
    exp_pc = exp_pc + 12;
    check("R7 taken branch target", pc, exp_pc);

    // R7: branch not taken
    place(iins(6'h04, 5'd1, 5'd2, 16'd3));
    fetch(); decode();
    run(0,1,2'd1,2'd1,1,2'd0,0,0,0,0,0,0,0);
    check("R7 untaken branch holds pc", pc, exp_pc);

    // R4: negative immediate through sign extension, PC from ALU output
    place(iins(6'h23, 5'd0, 5'd0, 16'hFFF0));
    fetch();
    run(1,0,2'd0,2'd0,0,2'd2,0,0,0,0,0,0,0);
    exp_pc = exp_pc - 16;
    check("R4 sign-extended negative offset", pc, exp_pc);

    // R2: instruction register holds when load is low
    run(0,0,2'd0,2'd0,0,2'd0,0,1,0,0,0,0,0);
    check("R2 opcode held without load", {26'd0, opcode}, 32'h23);

    // R3: read enable low gives zero data
    place(rins(5'd1, 5'd2, 5'd3, 6'h25));
    run(1,0,2'd0,2'd0,0,2'd1,0,0,0,0,0,1,0);
    exp_pc += 4;
    check("R3 read disabled loads zero", {20'd0, opcode, funct}, 32'h0);

    // R7: jump target
    place({6'h02, 26'h3C});
    fetch();
    run(1,0,2'd2,2'd0,0,2'd0,0,0,0,0,0,0,0);
    check("R7 jump target", pc, 32'h0000_00F0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule